// File: doc/BRIEF.md
# Memory Bus Cycle Type Classifier

This block sits beside a processor's outgoing memory request port and tags each clock cycle with a bus cycle type. The type tells a memory controller whether the current request continues from the previous transfer, so that the controller can keep a burst or an open page going. The type can also say that the request starts somewhere unrelated, or that the processor needs no transfer at all in this cycle.

The block keeps the address of the most recent real transfer. It compares the present request address with that stored address and with two forward steps from it: one halfword (2 bytes) and one word (4 bytes). Cycles with no transfer get the internal code and leave the stored address as it was. A step that would carry past the top of the address space does not count as a continuation.

The type is a combinational function of the present inputs and the stored state. The stored address is also brought out, so the controller can see which address the present request is compared against.

Top module: `buscyc_classifier`

## Requirements
- R1: `cycType` only ever takes the codes 2'b00 (nonsequential), 2'b01 (sequential) or 2'b10 (internal). It never takes 2'b11.
- R2: A cycle is a transfer only when `reqValid` is 1 and `reqInternal` is 0. In every other cycle, including one where both `reqValid` and `reqInternal` are 1, `cycType` is 2'b10.
- R3: The first transfer after reset is reported as 2'b00, whatever its address.
- R4: A transfer whose address equals the stored address is reported as 2'b01.
- R5: A transfer whose address is the stored address plus 4 is reported as 2'b01.
- R6: With the default configuration, a transfer whose address is the stored address plus 2 is reported as 2'b01. This holds whatever the `reqHalf` size flag was on either transfer.
- R7: A transfer whose address has any other relation to the stored address is reported as 2'b00. Examples are plus 1, plus 3, plus 8, and any step backwards.
- R8: A plus-2 or plus-4 step that carries past 32'hFFFF_FFFF (for example 32'hFFFF_FFFC followed by 32'h0) is reported as 2'b00.
- R9: `lastAddr` is 0 after reset. It takes the request address on the clock edge that ends each transfer cycle, and it holds its value through cycles that are not transfers.
- R10: After one or more non-transfer cycles, the next transfer is compared with the address of the last real transfer.
- R11: `cycType` reflects the inputs of the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | The processor presents a memory request this cycle |
| reqInternal | input | 1 | The processor is busy internally and needs no transfer |
| reqHalf | input | 1 | Transfer size: 1 for halfword, 0 for word |
| reqAddr | input | 32 | Byte address of the request |
| cycType | output | 2 | Cycle type: 00 nonsequential, 01 sequential, 10 internal |
| lastAddr | output | 32 | Address of the most recent real transfer |

## Verification
`cycType` is due in the same cycle as its inputs. The bench therefore drives the request on the falling edge and compares the type one nanosecond later, before the next rising edge can move the stored state. `lastAddr` is due one rising edge after a transfer cycle. The same mid-cycle sample compares it with the reference model's stored address, and the model updates that address only after the rising edge of a cycle it counted as a transfer. Directed steps cover each offset, the wrap at the top of the address space and reset. A long pseudo-random run then mixes the steps with idle and internal cycles.

// File: rtl/buscyc_pkg.sv
package buscyc_pkg;

  typedef enum logic [1:0] {
    CYC_NSEQ = 2'b00,
    CYC_SEQ  = 2'b01,
    CYC_INT  = 2'b10
  } cycKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // current cycle is a real transfer; load the address
  } ctlStrobe_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic same;
    logic stepWord;
    logic stepHalf;
  } addrHit_t;

endpackage

// File: rtl/buscyc_datapath.sv
module buscyc_datapath
  import buscyc_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int WORD_BYTES    = 4,
  parameter int HALF_BYTES    = 2,
  parameter bit HALF_STEP_ANY = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqHalf,
  output addrHit_t          hit,
  output logic [ADDR_W-1:0] lastAddr
);

  localparam int SUM_W = ADDR_W + 1;
  localparam logic [SUM_W-1:0] WORD_STEP = SUM_W'(WORD_BYTES);
  localparam logic [SUM_W-1:0] HALF_STEP = SUM_W'(HALF_BYTES);

  logic [ADDR_W-1:0] lastQ;
  logic              lastHalfQ;
  logic [SUM_W-1:0]  wordNext;
  logic [SUM_W-1:0]  halfNext;
  logic [SUM_W-1:0]  curWide;
  logic              halfOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastQ     <= '0;
      lastHalfQ <= 1'b0;
    end else if (strobe.capture) begin
      lastQ     <= reqAddr;
      lastHalfQ <= reqHalf;
    end
  end

  // one extra bit keeps a step that carries past the top from matching
  always_comb begin
    curWide  = {1'b0, reqAddr};
    wordNext = {1'b0, lastQ} + WORD_STEP;
    halfNext = {1'b0, lastQ} + HALF_STEP;
    halfOk   = HALF_STEP_ANY || lastHalfQ;
    hit.same     = (reqAddr == lastQ);
    hit.stepWord = (curWide == wordNext);
    hit.stepHalf = (curWide == halfNext) && halfOk;
  end

  assign lastAddr = lastQ;

  // R9
  lastaddr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(lastAddr));

  // R9
  lastaddr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (lastAddr == $past(reqAddr)));

  // R8
  wrap_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastAddr == {ADDR_W{1'b1}} - ADDR_W'(WORD_BYTES - 1) && reqAddr == '0) |-> !hit.stepWord);

endmodule

// File: rtl/buscyc_control.sv
module buscyc_control
  import buscyc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqInternal,
  input  addrHit_t   hit,
  output ctlStrobe_t strobe,
  output cycKind_e   cycType
);

  logic xfer;
  logic haveLastQ;
  logic anyHit;

  assign xfer   = reqValid && !reqInternal;
  assign anyHit = hit.same || hit.stepWord || hit.stepHalf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     haveLastQ <= 1'b0;
    else if (xfer) haveLastQ <= 1'b1;
  end

  always_comb begin
    strobe.capture = xfer;
    if (!xfer)                   cycType = CYC_INT;
    else if (haveLastQ && anyHit) cycType = CYC_SEQ;
    else                         cycType = CYC_NSEQ;
  end

  // R1
  code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycType != 2'b11);

  // R2
  no_xfer_internal_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqInternal) |-> cycType == CYC_INT);

  // R3
  first_nseq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && !haveLastQ) |-> cycType == CYC_NSEQ);

  // R4
  same_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && haveLastQ && hit.same) |-> cycType == CYC_SEQ);

  // R7
  miss_nseq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && !anyHit) |-> cycType == CYC_NSEQ);

endmodule

// File: rtl/buscyc_classifier.sv
module buscyc_classifier
  import buscyc_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int WORD_BYTES    = 4,
  parameter int HALF_BYTES    = 2,
  parameter bit HALF_STEP_ANY = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqInternal,
  input  logic              reqHalf,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        cycType,
  output logic [ADDR_W-1:0] lastAddr
);

  ctlStrobe_t strobe;
  addrHit_t   hit;
  cycKind_e   kind;

  buscyc_control uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqInternal (reqInternal),
    .hit         (hit),
    .strobe      (strobe),
    .cycType     (kind)
  );

  buscyc_datapath #(
    .ADDR_W        (ADDR_W),
    .WORD_BYTES    (WORD_BYTES),
    .HALF_BYTES    (HALF_BYTES),
    .HALF_STEP_ANY (HALF_STEP_ANY)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqHalf  (reqHalf),
    .hit      (hit),
    .lastAddr (lastAddr)
  );

  assign cycType = kind;

endmodule

// File: tb/tb_buscyc_classifier.sv
`timescale 1ns/1ps
module tb_buscyc_classifier;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqInternal = 1'b0;
  logic        reqHalf = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  cycType;
  logic [31:0] lastAddr;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit          refHave = 1'b0;
  logic [31:0] refLast = '0;

  always #2.5 clk = ~clk;

  buscyc_classifier dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqInternal(reqInternal),
    .reqHalf(reqHalf), .reqAddr(reqAddr), .cycType(cycType), .lastAddr(lastAddr)
  );

  function automatic logic [1:0] refType(input logic v, input logic i, input logic [31:0] a);
    longint unsigned prev;
    longint unsigned cur;
    prev = longint'(refLast);
    cur  = longint'(a);
    if (!v || i) return 2'b10;
    if (!refHave) return 2'b00;
    if (cur == prev || cur == prev + 4 || cur == prev + 2) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check2(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic i, input logic h, input logic [31:0] a, input string tag);
    logic [1:0] exp;
    @(negedge clk);
    reqValid = v; reqInternal = i; reqHalf = h; reqAddr = a;
    #1;
    exp = refType(v, i, a);
    check2({30'd0, cycType}, {30'd0, exp}, tag, "cycType");
    check2(lastAddr, refLast, tag, "lastAddr");
    @(posedge clk);
    if (v && !i) begin
      refHave = 1'b1;
      refLast = a;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] nxt;
    repeat (3) @(negedge clk);
    #1;
    // R9 reset value, R2 idle cycle is internal
    check2(lastAddr, 32'h0, "R9", "reset lastAddr");
    check2({30'd0, cycType}, 32'd2, "R2", "reset idle type");
    @(negedge clk);
    rstN = 1'b1;

    step(1, 0, 0, 32'h0000_0000, "R3");   // first transfer, equal to reset value, still nseq
    step(1, 0, 0, 32'h0000_0000, "R4");
    step(1, 0, 0, 32'h0000_0004, "R5");
    step(1, 0, 1, 32'h0000_0006, "R6");
    step(1, 0, 0, 32'h0000_0008, "R6");   // +2 after halfword, word size now
    step(1, 0, 0, 32'h0000_0009, "R7");   // +1
    step(1, 0, 0, 32'h0000_000C, "R7");   // +3
    step(1, 0, 0, 32'h0000_0014, "R7");   // +8
    step(1, 0, 0, 32'h0000_0010, "R7");   // backwards
    step(0, 0, 0, 32'h0000_0014, "R2");
    step(1, 1, 0, 32'h0000_0014, "R2");   // valid with internal wins
    step(0, 1, 0, 32'h1234_5678, "R9");
    step(1, 0, 0, 32'h0000_0014, "R10");  // +4 from last real transfer
    step(1, 0, 0, 32'hFFFF_FFFC, "R11");
    step(1, 0, 0, 32'h0000_0000, "R8");
    step(1, 0, 0, 32'hFFFF_FFFE, "R8");
    step(1, 0, 1, 32'h0000_0000, "R8");
    step(1, 0, 0, 32'hFFFF_FFFC, "R8");
    step(1, 0, 1, 32'hFFFF_FFFE, "R6");

    for (int n = 0; n < 2000; n++) begin
      int sel;
      sel = $urandom_range(0, 8);
      case (sel)
        0: nxt = refLast;
        1: nxt = refLast + 32'd2;
        2: nxt = refLast + 32'd4;
        3: nxt = refLast + 32'd1;
        4: nxt = refLast + 32'd8;
        5: nxt = refLast - 32'd4;
        6: nxt = 32'hFFFF_FFFC + 32'($urandom_range(0, 3));
        default: nxt = $urandom;
      endcase
      step($urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0,
           1'($urandom_range(0, 1)), nxt, "R1");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule